// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Sequencer

This block follows instruction tokens through a six-step in-order pipeline: fetch, decode, operand-address calculation, operand fetch, execute and write-back of the result. Each token is a small descriptor handed in by the fetch side. It holds a sequence tag, a flag that marks a conditional branch, a flag that says the branch is taken, and a target address. The block carries no instruction semantics and no operand data. It models only which tag sits in which stage, how tokens advance, how a stall freezes them and how a taken branch clears the younger work.

While no hazard is present, every valid token moves one stage per clock, so a full pipe retires one token per cycle. A taken branch resolves when it reaches execute. On that cycle the block raises a one-cycle redirect with the branch target. On the following edge it invalidates everything in the four earlier stages and the token offered at its input, lets the branch move on to the write stage, and loads the fetch address with the target. The fetch address otherwise counts up by one for every token it accepts.

The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the pipe stays empty for two clock edges after `rst_n` rises.

Top module: `pipe6_seq`

## Requirements
- R1: While reset is held, all six stage valid bits are 0, `fetch_addr` is 0 and `redir_valid` is 0.
- R2: With `stall` low and no redirect, on each edge stage k (k = 1..5) takes the contents of stage k-1, and stage 0 (fetch) takes the input descriptor, with its valid bit equal to `in_valid`.
- R3: A token accepted into fetch at one edge shows up in the write stage (index 5) five edges later, provided nothing stalls or flushes it on the way.
- R4: With `stall` high and no redirect, every stage and `fetch_addr` keep their values, and the input descriptor is dropped.
- R5: `redir_valid` is 1 exactly when the execute stage (index 4) holds a valid token with branch flag 1 and taken flag 1, and `redir_addr` then equals that token's target.
- R6: On the edge that ends a redirect cycle, stages 0 to 4 become invalid and the branch token moves into the write stage with its tag.
- R7: On the edge that ends a redirect cycle, `fetch_addr` is loaded with the branch target.
- R8: A redirect overrides `stall`: the flush, the move of the branch into the write stage and the fetch reload all take place even while `stall` is high.
- R9: A token whose branch flag is 0, or whose taken flag is 0, causes no redirect and no flush, whatever its other fields hold.
- R10: Without a redirect, `fetch_addr` goes up by one (modulo 2^16) on each edge where `in_valid` is 1 and `stall` is 0, and holds otherwise.
- R11: `redir_valid` is never high on two consecutive cycles, because the flush removes any branch that follows directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered to fetch this cycle |
| in_tag | input | 8 | Sequence tag of the offered descriptor |
| in_branch | input | 1 | Descriptor is a conditional branch |
| in_taken | input | 1 | Branch outcome is taken |
| in_target | input | 16 | Branch target address |
| stall | input | 1 | Freeze all stages this cycle |
| fetch_addr | output | 16 | Address of the next fetch |
| redir_valid | output | 1 | Taken branch in execute, one-cycle pulse |
| redir_addr | output | 16 | Target address that goes with the redirect |
| stg_valid | output | 6 | Valid bit per stage, bit 0 = fetch, bit 5 = write |
| stg_tag | output | 48 | Tag per stage, stage k at bits [8k+7:8k] |

## Verification
The checker assumes that `stall` and the descriptor inputs are driven to known values on every cycle after reset is released. It also assumes that `in_valid` stays low while the internal reset synchroniser is still draining, since the stage-advance property does not cover fetch during that window. The bench drives all inputs from time zero and changes them only at falling edges. After each reset release it idles with `in_valid` low for several cycles before it offers tokens. Branch targets are chosen so that the fetch reload can be told apart from the normal increment, and one of them also exercises the counter wrap.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;
  parameter int unsigned NSTG   = 6;
  parameter int unsigned TAG_W  = 8;
  parameter int unsigned ADDR_W = 16;

  // Stage positions; execute and write are counted from the end of the pipe
  localparam int unsigned ST_FI = 0;
  localparam int unsigned ST_EI = NSTG - 2;
  localparam int unsigned ST_WO = NSTG - 1;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic  vld;
    tag_t  tag;
    logic  br;
    logic  tk;
    addr_t tgt;
  } slot_t;
endpackage

// File: rtl/pipe6_rst_sync.sv
module pipe6_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[DEPTH-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[DEPTH-1];
endmodule

// File: rtl/pipe6_slot_reg.sv
module pipe6_slot_reg
  import pipe6_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  kill_i,
  input  slot_t d_i,
  output slot_t q_o
);
  slot_t q_r;
  slot_t q_nxt;

  always_comb begin
    q_nxt = d_i;
    if (kill_i) q_nxt.vld = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (adv_i) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/pipe6_redirect.sv
module pipe6_redirect
  import pipe6_pkg::*;
(
  input  slot_t ex_i,
  output logic  redir_o,
  output addr_t addr_o
);
  always_comb begin
    redir_o = ex_i.vld & ex_i.br & ex_i.tk;
    addr_o  = ex_i.tgt;
  end
endmodule

// File: rtl/pipe6_fetch_ctr.sv
module pipe6_fetch_ctr
  import pipe6_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept_i,
  input  logic  redir_i,
  input  addr_t tgt_i,
  output addr_t addr_o
);
  addr_t addr_r;
  addr_t addr_nxt;
  logic  addr_en;

  always_comb begin
    addr_en  = accept_i | redir_i;
    addr_nxt = redir_i ? tgt_i : addr_r + addr_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_r <= '0;
    else if (addr_en) addr_r <= addr_nxt;
  end

  assign addr_o = addr_r;
endmodule

// File: rtl/pipe6_seq.sv
module pipe6_seq
  import pipe6_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic                  in_branch,
  input  logic                  in_taken,
  input  logic [ADDR_W-1:0]     in_target,
  input  logic                  stall,
  output logic [ADDR_W-1:0]     fetch_addr,
  output logic                  redir_valid,
  output logic [ADDR_W-1:0]     redir_addr,
  output logic [NSTG-1:0]       stg_valid,
  output logic [NSTG*TAG_W-1:0] stg_tag
);
  logic  rst_core_n;
  logic  flush;
  logic  adv;
  logic  accept;
  addr_t flush_tgt;
  slot_t fin;
  slot_t slot [NSTG];

  pipe6_rst_sync #(.DEPTH(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    fin.vld = in_valid;
    fin.tag = in_tag;
    fin.br  = in_branch;
    fin.tk  = in_taken;
    fin.tgt = in_target;
  end

  pipe6_redirect u_redir (
    .ex_i    (slot[ST_EI]),
    .redir_o (flush),
    .addr_o  (flush_tgt)
  );

  // a redirect forces a step even under stall
  assign adv    = ~stall | flush;
  assign accept = in_valid & ~stall & ~flush;

  for (genvar gi = 0; gi < NSTG; gi++) begin : g_stage
    slot_t d_s;
    logic  kill_s;
    if (gi == ST_FI) begin : g_head
      assign d_s = fin;
    end else begin : g_body
      assign d_s = slot[gi-1];
    end
    // stages up to execute receive work younger than the branch
    if (gi <= ST_EI) begin : g_young
      assign kill_s = flush;
    end else begin : g_old
      assign kill_s = 1'b0;
    end
    pipe6_slot_reg u_slot (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .adv_i  (adv),
      .kill_i (kill_s),
      .d_i    (d_s),
      .q_o    (slot[gi])
    );
    assign stg_valid[gi]               = slot[gi].vld;
    assign stg_tag[gi*TAG_W +: TAG_W]  = slot[gi].tag;
  end

  pipe6_fetch_ctr u_fetch (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .accept_i (accept),
    .redir_i  (flush),
    .tgt_i    (flush_tgt),
    .addr_o   (fetch_addr)
  );

  assign redir_valid = flush;
  assign redir_addr  = flush_tgt;
endmodule

// File: rtl/pipe6_seq_chk.sv
module pipe6_seq_chk
  import pipe6_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  stall,
  input logic [ADDR_W-1:0]     fetch_addr,
  input logic                  redir_valid,
  input logic [ADDR_W-1:0]     redir_addr,
  input logic [NSTG-1:0]       stg_valid,
  input logic [NSTG*TAG_W-1:0] stg_tag
);
  assert_redir_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !redir_valid);

  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (stg_valid[ST_EI:0] == '0));

  assert_branch_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (stg_valid[ST_WO] &&
      stg_tag[ST_WO*TAG_W +: TAG_W] == $past(stg_tag[ST_EI*TAG_W +: TAG_W])));

  assert_fetch_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (fetch_addr == $past(redir_addr)));

  assert_flush_beats_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && stall) |=> stg_valid[ST_WO]);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redir_valid) |=> ($stable(stg_valid) && $stable(stg_tag) && $stable(fetch_addr)));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redir_valid) |=> (stg_valid[NSTG-1:1] == $past(stg_valid[NSTG-2:0])));

  assert_fetch_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redir_valid && in_valid) |=> (fetch_addr == $past(fetch_addr) + 16'd1));
endmodule

bind pipe6_seq pipe6_seq_chk u_pipe6_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .stall       (stall),
  .fetch_addr  (fetch_addr),
  .redir_valid (redir_valid),
  .redir_addr  (redir_addr),
  .stg_valid   (stg_valid),
  .stg_tag     (stg_tag)
);

// File: tb/test_pipe6_seq.sv
module test_pipe6_seq;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NROWS = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_tag = '0;
  logic        in_branch = 1'b0;
  logic        in_taken = 1'b0;
  logic [15:0] in_target = '0;
  logic        stall = 1'b0;
  logic [15:0] fetch_addr;
  logic        redir_valid;
  logic [15:0] redir_addr;
  logic [5:0]  stg_valid;
  logic [47:0] stg_tag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  pipe6_seq i_pipe6_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_branch(in_branch), .in_taken(in_taken), .in_target(in_target),
    .stall(stall), .fetch_addr(fetch_addr), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .stg_valid(stg_valid), .stg_tag(stg_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        iv;
    logic [7:0]  tag;
    logic        br;
    logic        tk;
    logic [15:0] tgt;
    logic        st;
    logic [5:0]  ev;
    logic [7:0]  ewr;
    logic [15:0] efa;
    logic        erd;
  } vec_t;

  // inputs for one cycle, then the state expected after the following edge
  localparam vec_t VEC [NROWS] = '{
    '{1'b1, 8'd1,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b000001, 8'd0,  16'h0001, 1'b0},
    '{1'b1, 8'd2,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b000011, 8'd0,  16'h0002, 1'b0},
    '{1'b1, 8'd3,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b000111, 8'd0,  16'h0003, 1'b0},
    '{1'b1, 8'd4,  1'b1, 1'b1, 16'h0040, 1'b0, 6'b001111, 8'd0,  16'h0004, 1'b0},
    '{1'b1, 8'd5,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b011111, 8'd0,  16'h0005, 1'b0},
    '{1'b1, 8'd6,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b111111, 8'd1,  16'h0006, 1'b0},
    '{1'b1, 8'd7,  1'b0, 1'b0, 16'h0000, 1'b1, 6'b111111, 8'd1,  16'h0006, 1'b0},
    '{1'b1, 8'd7,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b111111, 8'd2,  16'h0007, 1'b0},
    '{1'b1, 8'd8,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b111111, 8'd3,  16'h0008, 1'b1},
    '{1'b1, 8'd9,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b100000, 8'd4,  16'h0040, 1'b0},
    '{1'b1, 8'd20, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000001, 8'd0,  16'h0041, 1'b0},
    '{1'b1, 8'd21, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b000011, 8'd0,  16'h0042, 1'b0},
    '{1'b1, 8'd22, 1'b1, 1'b0, 16'h0090, 1'b0, 6'b000111, 8'd0,  16'h0043, 1'b0},
    '{1'b1, 8'd23, 1'b0, 1'b1, 16'h00A0, 1'b0, 6'b001111, 8'd0,  16'h0044, 1'b0},
    '{1'b1, 8'd24, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b011111, 8'd0,  16'h0045, 1'b0},
    '{1'b1, 8'd25, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b111111, 8'd20, 16'h0046, 1'b0},
    '{1'b1, 8'd26, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b111111, 8'd21, 16'h0047, 1'b0},
    '{1'b1, 8'd27, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b111111, 8'd22, 16'h0048, 1'b0},
    '{1'b1, 8'd28, 1'b0, 1'b0, 16'h0000, 1'b0, 6'b111111, 8'd23, 16'h0049, 1'b0},
    '{1'b0, 8'd0,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b111110, 8'd24, 16'h0049, 1'b0},
    '{1'b0, 8'd0,  1'b0, 1'b0, 16'h0000, 1'b0, 6'b111100, 8'd25, 16'h0049, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic [7:0] tag, input logic br,
                       input logic tk, input logic [15:0] tgt, input logic st);
    in_valid = iv; in_tag = tag; in_branch = br;
    in_taken = tk; in_target = tgt; stall = st;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    drive(1'b0, 8'd0, 1'b0, 1'b0, 16'h0, 1'b0);
    rst_n = 1'b0;
    step();
    check("R1", "valid in reset", 32'(stg_valid), 32'd0);
    check("R1", "fetch_addr in reset", 32'(fetch_addr), 32'd0);
    check("R1", "redirect in reset", 32'(redir_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    string lv, lf, lr;
    logic  prev_rd;
    @(negedge clk);
    do_reset();

    prev_rd = 1'b0;
    for (int k = 0; k < NROWS; k++) begin
      drive(VEC[k].iv, VEC[k].tag, VEC[k].br, VEC[k].tk, VEC[k].tgt, VEC[k].st);
      step();
      lv = VEC[k].st ? "R4" : (prev_rd ? "R6" : "R2");
      lf = VEC[k].st ? "R4" : (prev_rd ? "R7" : "R10");
      lr = VEC[k].erd ? "R5" : "R9";
      check(lv, $sformatf("row %0d valid", k), 32'(stg_valid), 32'(VEC[k].ev));
      if (VEC[k].ev[5])
        check("R3", $sformatf("row %0d write tag", k), 32'(stg_tag[47:40]), 32'(VEC[k].ewr));
      check(lf, $sformatf("row %0d fetch_addr", k), 32'(fetch_addr), 32'(VEC[k].efa));
      check(lr, $sformatf("row %0d redirect", k), 32'(redir_valid), 32'(VEC[k].erd));
      if (VEC[k].erd)
        check("R5", $sformatf("row %0d target", k), 32'(redir_addr), 32'h40);
      prev_rd = VEC[k].erd;
    end

    // mid-run reset empties a loaded pipe
    do_reset();

    // two taken branches back to back; the second is flushed by the first
    drive(1'b1, 8'd1, 1'b1, 1'b1, 16'hFFFF, 1'b0); step();
    drive(1'b1, 8'd2, 1'b1, 1'b1, 16'h0020, 1'b0); step();
    drive(1'b1, 8'd3, 1'b0, 1'b0, 16'h0000, 1'b0); step();
    drive(1'b1, 8'd4, 1'b0, 1'b0, 16'h0000, 1'b0); step();
    drive(1'b1, 8'd5, 1'b0, 1'b0, 16'h0000, 1'b0); step();
    check("R5", "redirect with branch in execute", 32'(redir_valid), 32'd1);
    check("R5", "redirect target", 32'(redir_addr), 32'hFFFF);
    // flush under stall
    drive(1'b1, 8'd6, 1'b0, 1'b0, 16'h0000, 1'b1); step();
    check("R8", "flush under stall valid", 32'(stg_valid), 32'b100000);
    check("R6", "branch tag in write", 32'(stg_tag[47:40]), 32'd1);
    check("R7", "fetch reload under stall", 32'(fetch_addr), 32'hFFFF);
    check("R11", "no second redirect", 32'(redir_valid), 32'd0);
    drive(1'b1, 8'd7, 1'b0, 1'b0, 16'h0000, 1'b0); step();
    check("R10", "fetch address wrap", 32'(fetch_addr), 32'h0000);
    check("R2", "target token in fetch", 32'(stg_valid), 32'b000001);
    check("R2", "target token tag", 32'(stg_tag[7:0]), 32'd7);
    drive(1'b0, 8'd0, 1'b0, 1'b0, 16'h0000, 1'b0); step();

    finish_run();
  end
endmodule